// File: doc/BRIEF.md
# Configuration EEPROM Auto-Loader

This block fills a device's configuration registers after a reset. It reads an attached serial EEPROM one byte at a time through a simple request/acknowledge port that serves an EEPROM access engine. The first byte it reads is a signature. When the signature matches, the block copies the MAC address, the two polling intervals, the configuration flags, the maximum power, the vendor ID and the product ID out of the EEPROM. When the signature does not match, it treats the EEPROM as missing or blank and loads a built-in default image. In that default image, bit 2 of the configuration flags follows the remote-wakeup strap.

A power-on, pin or software reset request starts a full load. A USB reset request starts a reload that touches only the MAC address. A new request that arrives during a load abandons that load and starts again from the signature. When a full request and a MAC-only request compete, the full kind wins. Completion is signalled by a one-cycle done pulse and a level valid flag.

Top module: `cfg_autoload`

## Requirements
- R1: While `rstN` is low, the outputs hold the default image (MAC FFFFFFFFFFFFh, full-speed interval 01h, high-speed interval 04h, flags 04h, power FAh, vendor 0424h, product 9730h), and `rdReq`, `loadDone` and `cfgValid` are low. After `rstN` is released, a full load begins: `rdReq` is high at address 0 after the first clock edge.
- R2: The block has only one read outstanding at a time. `rdReq` stays high with `rdAddr` held stable until `rdAck`, which qualifies `rdData` in the same cycle. The first read of every load goes to address 0, and the following reads step up by one address. A value other than A5h at address 0 ends the load with no further reads.
- R3: When the signature is valid, a full load reads addresses 1 to 14 and maps them as follows: bytes 1-6 are the MAC address (byte 1 is the least significant byte), byte 7 is the full-speed interval, byte 8 is the high-speed interval, byte 9 is the flags, byte 10 is the power, bytes 11-12 are the vendor ID and bytes 13-14 are the product ID (both low byte first).
- R4: When the signature is not valid, a full load writes the default image of R1 into every field, except that flags bit 2 equals `wakeStrap` and the other flag bits are 0.
- R5: When the signature is valid, `wakeStrap` has no effect: the flags equal EEPROM byte 9 exactly.
- R6: A `usbReq` with a valid signature reads only addresses 0 to 6, updates only `macAddr`, and leaves every other field unchanged.
- R7: A `usbReq` with an invalid signature sets `macAddr` to all ones and leaves every other field unchanged.
- R8: `loadDone` is high for exactly one cycle when a load completes, and `cfgValid` is high from that point on. `cfgValid` goes low on the clock edge that accepts any load request.
- R9: A request that arrives while a load is running restarts the load at address 0 on the next cycle. An acknowledge in the same cycle as the request is discarded, and the abandoned load never raises `loadDone`.
- R10: A full request (`porReq`, `pinReq` or `swReq`) in the same cycle as `usbReq` gives a full load. A `usbReq` that interrupts an unfinished full load also restarts as a full load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| porReq | input | 1 | Power-on reset request, one-cycle pulse, full load |
| pinReq | input | 1 | External reset pin request, one-cycle pulse, full load |
| swReq | input | 1 | Software reset request, one-cycle pulse, full load |
| usbReq | input | 1 | USB reset request, one-cycle pulse, MAC-only load |
| wakeStrap | input | 1 | Remote-wakeup strap, drives flags bit 2 in the default image |
| rdReq | output | 1 | Byte-read request toward the EEPROM engine |
| rdAddr | output | ADDR_W | EEPROM byte address of the pending read |
| rdAck | input | 1 | Read acknowledge; `rdData` is valid in this cycle |
| rdData | input | 8 | Byte returned by the EEPROM engine |
| macAddr | output | 48 | MAC address |
| fsPoll | output | 8 | Full-speed polling interval (ms) |
| hsPoll | output | 8 | High-speed polling interval (ms) |
| cfgFlags | output | 8 | Configuration flags |
| maxPower | output | 8 | Maximum power |
| vendorId | output | 16 | Vendor ID |
| productId | output | 16 | Product ID |
| loadDone | output | 1 | One-cycle pulse when a load finishes |
| cfgValid | output | 1 | Set when a load has finished, cleared when a new load starts |

## Verification
Two events can fall in the same cycle: a read acknowledge that would finish or advance a load, and a new reset request that must abort that load. The bench provokes this from its EEPROM model, which raises `swReq` in the very cycle it acknowledges the final byte (address 14). A correct block drops that byte and restarts at address 0. It then raises exactly one `loadDone`, after 30 reads in total. A second collision puts a full request and a USB request in one cycle, and the bench judges it by the read count and by the non-MAC fields that get rewritten.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;

  typedef enum logic [1:0] {
    ST_START,
    ST_IDLE,
    ST_READ
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrByte;   // store rdData at byteIdx
    logic [3:0] byteIdx;  // EEPROM byte index being returned
    logic       defFull;  // apply the whole default image
    logic       defMac;   // apply the default MAC only
  } dpCtrl_t;

  localparam int IDX_W         = 4;
  localparam int MAC_BYTES     = 6;
  localparam int IDX_MAC_LO    = 1;
  localparam int IDX_FS        = IDX_MAC_LO + MAC_BYTES;
  localparam int IDX_HS        = IDX_FS + 1;
  localparam int IDX_FLAGS     = IDX_HS + 1;
  localparam int IDX_PWR       = IDX_FLAGS + 1;
  localparam int IDX_VID_LO    = IDX_PWR + 1;
  localparam int IDX_VID_HI    = IDX_VID_LO + 1;
  localparam int IDX_PID_LO    = IDX_VID_HI + 1;
  localparam int IDX_PID_HI    = IDX_PID_LO + 1;
  localparam int IDX_LAST_MAC  = IDX_MAC_LO + MAC_BYTES - 1;
  localparam int IDX_LAST_FULL = IDX_PID_HI;
  localparam int WAKE_BIT      = 2;

endpackage

// File: rtl/cfg_autoload_ctrl.sv
module cfg_autoload_ctrl
  import cfg_autoload_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  SIG    = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porReq,
  input  logic              pinReq,
  input  logic              swReq,
  input  logic              usbReq,
  input  logic              rdAck,
  input  logic [7:0]        rdData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output dpCtrl_t           dpCtrl,
  output logic              loadDone,
  output logic              cfgValid
);

  ldState_t          state;
  logic [IDX_W-1:0]  idx;
  logic              kindFull;
  logic              fullReq, anyReq, ackHit, sigOk, lastByte, finish;

  assign fullReq  = porReq | pinReq | swReq;
  assign anyReq   = fullReq | usbReq;
  // a request in the same cycle as an acknowledge wins; the byte is dropped
  assign ackHit   = (state == ST_READ) && rdAck && !anyReq;
  assign sigOk    = (rdData == SIG);
  assign lastByte = kindFull ? (idx == IDX_W'(IDX_LAST_FULL))
                             : (idx == IDX_W'(IDX_LAST_MAC));
  assign finish   = ackHit && ((idx == '0) ? !sigOk : lastByte);

  assign rdReq  = (state == ST_READ);
  assign rdAddr = {{(ADDR_W-IDX_W){1'b0}}, idx};

  always_comb begin
    dpCtrl.wrByte  = ackHit && (idx != '0);
    dpCtrl.byteIdx = idx;
    dpCtrl.defFull = ackHit && (idx == '0) && !sigOk && kindFull;
    dpCtrl.defMac  = ackHit && (idx == '0) && !sigOk && !kindFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_START;
      idx      <= '0;
      kindFull <= 1'b1;
      loadDone <= 1'b0;
      cfgValid <= 1'b0;
    end else begin
      loadDone <= 1'b0;
      if (anyReq) begin
        state    <= ST_READ;
        idx      <= '0;
        // an interrupted full load must stay full
        kindFull <= fullReq | ((state != ST_IDLE) & kindFull);
        cfgValid <= 1'b0;
      end else begin
        unique case (state)
          ST_START: begin
            state <= ST_READ;
            idx   <= '0;
          end
          ST_READ: begin
            if (finish) begin
              state    <= ST_IDLE;
              loadDone <= 1'b1;
              cfgValid <= 1'b1;
            end else if (ackHit) begin
              idx <= idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_autoload_dp.sv
module cfg_autoload_dp
  import cfg_autoload_pkg::*;
#(
  parameter logic [47:0] DEF_MAC   = 48'hFFFF_FFFF_FFFF,
  parameter logic [7:0]  DEF_FS    = 8'h01,
  parameter logic [7:0]  DEF_HS    = 8'h04,
  parameter logic [7:0]  DEF_FLAGS = 8'h04,
  parameter logic [7:0]  DEF_PWR   = 8'hFA,
  parameter logic [15:0] DEF_VID   = 16'h0424,
  parameter logic [15:0] DEF_PID   = 16'h9730
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtrl_t     ctl,
  input  logic [7:0]  rdData,
  input  logic        wakeStrap,
  output logic [47:0] macAddr,
  output logic [7:0]  fsPoll,
  output logic [7:0]  hsPoll,
  output logic [7:0]  cfgFlags,
  output logic [7:0]  maxPower,
  output logic [15:0] vendorId,
  output logic [15:0] productId
);

  localparam logic [7:0] WAKE_MASK = 8'(1 << WAKE_BIT);

  logic [7:0] flagsDef;
  logic [7:0] macLane [MAC_BYTES];

  assign flagsDef = (DEF_FLAGS & ~WAKE_MASK) | (wakeStrap ? WAKE_MASK : 8'h00);

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        macLane[g] <= DEF_MAC[8*g +: 8];
      else if (ctl.defFull || ctl.defMac)
        macLane[g] <= DEF_MAC[8*g +: 8];
      else if (ctl.wrByte && (ctl.byteIdx == IDX_W'(IDX_MAC_LO + g)))
        macLane[g] <= rdData;
    end
    assign macAddr[8*g +: 8] = macLane[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPoll    <= DEF_FS;
      hsPoll    <= DEF_HS;
      cfgFlags  <= DEF_FLAGS;
      maxPower  <= DEF_PWR;
      vendorId  <= DEF_VID;
      productId <= DEF_PID;
    end else if (ctl.defFull) begin
      fsPoll    <= DEF_FS;
      hsPoll    <= DEF_HS;
      cfgFlags  <= flagsDef;
      maxPower  <= DEF_PWR;
      vendorId  <= DEF_VID;
      productId <= DEF_PID;
    end else if (ctl.wrByte) begin
      case (ctl.byteIdx)
        IDX_W'(IDX_FS):     fsPoll          <= rdData;
        IDX_W'(IDX_HS):     hsPoll          <= rdData;
        IDX_W'(IDX_FLAGS):  cfgFlags        <= rdData;
        IDX_W'(IDX_PWR):    maxPower        <= rdData;
        IDX_W'(IDX_VID_LO): vendorId[7:0]   <= rdData;
        IDX_W'(IDX_VID_HI): vendorId[15:8]  <= rdData;
        IDX_W'(IDX_PID_LO): productId[7:0]  <= rdData;
        IDX_W'(IDX_PID_HI): productId[15:8] <= rdData;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_autoload_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  SIG       = 8'hA5,
  parameter logic [47:0] DEF_MAC   = 48'hFFFF_FFFF_FFFF,
  parameter logic [7:0]  DEF_FS    = 8'h01,
  parameter logic [7:0]  DEF_HS    = 8'h04,
  parameter logic [7:0]  DEF_FLAGS = 8'h04,
  parameter logic [7:0]  DEF_PWR   = 8'hFA,
  parameter logic [15:0] DEF_VID   = 16'h0424,
  parameter logic [15:0] DEF_PID   = 16'h9730
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porReq,
  input  logic              pinReq,
  input  logic              swReq,
  input  logic              usbReq,
  input  logic              wakeStrap,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [7:0]        rdData,
  output logic [47:0]       macAddr,
  output logic [7:0]        fsPoll,
  output logic [7:0]        hsPoll,
  output logic [7:0]        cfgFlags,
  output logic [7:0]        maxPower,
  output logic [15:0]       vendorId,
  output logic [15:0]       productId,
  output logic              loadDone,
  output logic              cfgValid
);

  dpCtrl_t dpCtrl;

  cfg_autoload_ctrl #(.ADDR_W(ADDR_W), .SIG(SIG)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .porReq(porReq), .pinReq(pinReq), .swReq(swReq), .usbReq(usbReq),
    .rdAck(rdAck), .rdData(rdData),
    .rdReq(rdReq), .rdAddr(rdAddr),
    .dpCtrl(dpCtrl), .loadDone(loadDone), .cfgValid(cfgValid)
  );

  cfg_autoload_dp #(
    .DEF_MAC(DEF_MAC), .DEF_FS(DEF_FS), .DEF_HS(DEF_HS), .DEF_FLAGS(DEF_FLAGS),
    .DEF_PWR(DEF_PWR), .DEF_VID(DEF_VID), .DEF_PID(DEF_PID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtrl), .rdData(rdData), .wakeStrap(wakeStrap),
    .macAddr(macAddr), .fsPoll(fsPoll), .hsPoll(hsPoll), .cfgFlags(cfgFlags),
    .maxPower(maxPower), .vendorId(vendorId), .productId(productId)
  );

endmodule

// File: rtl/cfg_autoload_chk.sv
module cfg_autoload_chk #(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] SIG    = 8'hA5
) (
  input logic              clk,
  input logic              rstN,
  input logic              porReq,
  input logic              pinReq,
  input logic              swReq,
  input logic              usbReq,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdAck,
  input logic [7:0]        rdData,
  input logic [47:0]       macAddr,
  input logic [7:0]        fsPoll,
  input logic [7:0]        hsPoll,
  input logic [7:0]        cfgFlags,
  input logic [7:0]        maxPower,
  input logic [15:0]       vendorId,
  input logic [15:0]       productId,
  input logic              loadDone,
  input logic              cfgValid
);

  logic anyReq;
  assign anyReq = porReq | pinReq | swReq | usbReq;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  p_done_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> cfgValid);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> (rdReq && (rdAddr == '0) && !loadDone && !cfgValid));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck && !anyReq) |=> (rdReq && $stable(rdAddr)));

  p_bad_sig_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && (rdAddr == '0) && rdAck && (rdData != SIG) && !anyReq)
      |=> (loadDone && !rdReq));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rdReq && !anyReq) |=>
      $stable({macAddr, fsPoll, hsPoll, cfgFlags, maxPower, vendorId, productId}));

endmodule

bind cfg_autoload cfg_autoload_chk #(.ADDR_W(ADDR_W), .SIG(SIG)) u_chk (
  .clk(clk), .rstN(rstN), .porReq(porReq), .pinReq(pinReq), .swReq(swReq),
  .usbReq(usbReq), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
  .macAddr(macAddr), .fsPoll(fsPoll), .hsPoll(hsPoll), .cfgFlags(cfgFlags),
  .maxPower(maxPower), .vendorId(vendorId), .productId(productId),
  .loadDone(loadDone), .cfgValid(cfgValid)
);

// File: tb/tb_cfg_autoload.sv
module tb_cfg_autoload;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, porReq, pinReq, swMain, injReq, swReq, usbReq, wakeStrap;
  logic        rdReq, rdAck, loadDone, cfgValid;
  logic [7:0]  rdAddr, rdData, fsPoll, hsPoll, cfgFlags, maxPower;
  logic [47:0] macAddr;
  logic [15:0] vendorId, productId;

  assign swReq = swMain | injReq;

  cfg_autoload dut (
    .clk(clk), .rstN(rstN), .porReq(porReq), .pinReq(pinReq), .swReq(swReq),
    .usbReq(usbReq), .wakeStrap(wakeStrap), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdData(rdData), .macAddr(macAddr), .fsPoll(fsPoll),
    .hsPoll(hsPoll), .cfgFlags(cfgFlags), .maxPower(maxPower),
    .vendorId(vendorId), .productId(productId), .loadDone(loadDone),
    .cfgValid(cfgValid)
  );

  int checks = 0;
  int errors = 0;

  // EEPROM model state
  logic [7:0] mem [16];
  int         lat = 0;
  int         cnt = 0;
  bit         inject = 0;
  logic [7:0] injAddr = 8'd0;
  logic [7:0] addrLog [256];
  int         logCnt = 0;
  int         doneCnt = 0;

  // expected field values
  logic [47:0] eMac = 48'hFFFF_FFFF_FFFF;
  logic [7:0]  eFs = 8'h01, eHs = 8'h04, eFl = 8'h04, ePw = 8'hFA;
  logic [15:0] eVid = 16'h0424, ePid = 16'h9730;

  typedef struct packed {
    logic [7:0] sig;
    logic       usb;
    logic       strap;
    logic [1:0] lat;
    logic [7:0] seed;
    logic [7:0] reads;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1'b0, 1'b0, 2'd0, 8'd10,  8'd15},
    '{8'hA5, 1'b0, 1'b1, 2'd2, 8'd33,  8'd15},
    '{8'h5A, 1'b0, 1'b1, 2'd1, 8'd50,  8'd1},
    '{8'h00, 1'b0, 1'b0, 2'd0, 8'd7,   8'd1},
    '{8'hA5, 1'b1, 1'b1, 2'd1, 8'd90,  8'd7},
    '{8'hFF, 1'b1, 1'b0, 2'd0, 8'd1,   8'd1},
    '{8'hA5, 1'b0, 1'b0, 2'd3, 8'd200, 8'd15}
  };

  // EEPROM engine model: one-cycle acknowledge after lat idle cycles
  initial begin
    rdAck = 1'b0; rdData = 8'h00; injReq = 1'b0;
    forever begin
      @(negedge clk);
      injReq = 1'b0;
      if (rdAck) begin
        rdAck = 1'b0;
        cnt   = 0;
      end else if (rdReq) begin
        if (cnt >= lat) begin
          rdAck  = 1'b1;
          rdData = mem[rdAddr[3:0]];
          if (logCnt < 256) addrLog[logCnt] = rdAddr;
          logCnt++;
          if (inject && rdAddr == injAddr) begin
            injReq = 1'b1;
            inject = 0;
          end
        end else cnt++;
      end else cnt = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (loadDone) doneCnt++;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] curFields();
    return {16'h0, macAddr, fsPoll, hsPoll, cfgFlags, maxPower, vendorId, productId};
  endfunction

  function automatic logic [127:0] expFields();
    return {16'h0, eMac, eFs, eHs, eFl, ePw, eVid, ePid};
  endfunction

  task automatic fillMem(input logic [7:0] sig, input logic [7:0] seed);
    mem[0] = sig;
    for (int i = 1; i < 16; i++) mem[i] = seed + 8'(i * 37);
  endtask

  // expected result of a completed load, from the requirements
  task automatic model(input bit full, input bit strap);
    if (mem[0] == 8'hA5) begin
      for (int k = 0; k < 6; k++) eMac[8*k +: 8] = mem[1+k];
      if (full) begin
        eFs = mem[7]; eHs = mem[8]; eFl = mem[9]; ePw = mem[10];
        eVid = {mem[12], mem[11]}; ePid = {mem[14], mem[13]};
      end
    end else begin
      eMac = 48'hFFFF_FFFF_FFFF;
      if (full) begin
        eFs = 8'h01; eHs = 8'h04; eFl = strap ? 8'h04 : 8'h00; ePw = 8'hFA;
        eVid = 16'h0424; ePid = 16'h9730;
      end
    end
  endtask

  task automatic waitDone(input string req);
    int t = 0;
    while (!loadDone && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk(req, 0, 1);
  endtask

  // the last 15 logged reads must be addresses 0..14 in order
  task automatic chkLastFull(input string req);
    bit ok = 1;
    for (int k = 0; k < 15; k++)
      if (addrLog[logCnt-15+k] != 8'(k)) ok = 0;
    chk(req, 128'(ok), 1);
  endtask

  initial begin
    int base, dBase;
    string tag;
    rstN = 1'b0; porReq = 0; pinReq = 0; swMain = 0; usbReq = 0; wakeStrap = 0;
    fillMem(8'h00, 8'd3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", curFields(), {16'h0, 48'hFFFF_FFFF_FFFF, 8'h01, 8'h04, 8'h04, 8'hFA, 16'h0424, 16'h9730});
    chk("R1", {rdReq, loadDone, cfgValid}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {rdReq, rdAddr}, {1'b1, 8'h00});
    waitDone("R1");
    model(1, 0);
    chk("R4", curFields(), expFields());
    chk("R2", logCnt, 1);
    chk("R8", cfgValid, 1);

    // table of scenarios
    for (int v = 0; v < NVEC; v++) begin
      fillMem(VECS[v].sig, VECS[v].seed);
      wakeStrap = VECS[v].strap;
      lat = int'(VECS[v].lat);
      tag = VECS[v].usb ? ((VECS[v].sig == 8'hA5) ? "R6" : "R7")
                        : ((VECS[v].sig == 8'hA5) ? (VECS[v].strap ? "R5" : "R3") : "R4");
      base = logCnt;
      @(negedge clk);
      if (VECS[v].usb) usbReq = 1; else porReq = 1;
      @(negedge clk);
      usbReq = 0; porReq = 0;
      chk("R8", cfgValid, 0);
      waitDone(tag);
      @(negedge clk);
      chk("R8", {loadDone, cfgValid}, 2'b01);
      model(!VECS[v].usb, VECS[v].strap);
      chk(tag, curFields(), expFields());
      chk("R2", logCnt - base, int'(VECS[v].reads));
      begin
        bit ok = 1;
        for (int k = 0; k < int'(VECS[v].reads); k++)
          if (addrLog[base+k] != 8'(k)) ok = 0;
        chk("R2", 128'(ok), 1);
      end
    end

    // R9: request in the same cycle as the final acknowledge
    fillMem(8'hA5, 8'd160); lat = 1; wakeStrap = 1;
    inject = 1; injAddr = 8'd14;
    base = logCnt; dBase = doneCnt;
    @(negedge clk); porReq = 1;
    @(negedge clk); porReq = 0;
    waitDone("R9");
    @(negedge clk);
    chk("R9", logCnt - base, 30);
    chk("R9", doneCnt - dBase, 1);
    chkLastFull("R9");
    model(1, 1);
    chk("R9", curFields(), expFields());

    // R9: software request in the middle of a slow load
    fillMem(8'hA5, 8'd180); lat = 3;
    base = logCnt; dBase = doneCnt;
    @(negedge clk); porReq = 1;
    @(negedge clk); porReq = 0;
    while (logCnt < base + 3) @(negedge clk);
    swMain = 1;
    @(negedge clk); swMain = 0;
    waitDone("R9");
    @(negedge clk);
    chk("R9", doneCnt - dBase, 1);
    chkLastFull("R9");
    model(1, 1);
    chk("R9", curFields(), expFields());

    // R10: full and USB request together
    fillMem(8'hA5, 8'd120); lat = 0; wakeStrap = 0;
    base = logCnt;
    @(negedge clk); pinReq = 1; usbReq = 1;
    @(negedge clk); pinReq = 0; usbReq = 0;
    waitDone("R10");
    chk("R10", logCnt - base, 15);
    model(1, 0);
    chk("R10", curFields(), expFields());

    // R10: USB request interrupting a full load
    fillMem(8'hA5, 8'd140); lat = 2;
    base = logCnt; dBase = doneCnt;
    @(negedge clk); porReq = 1;
    @(negedge clk); porReq = 0;
    while (logCnt < base + 5) @(negedge clk);
    usbReq = 1;
    @(negedge clk); usbReq = 0;
    waitDone("R10");
    @(negedge clk);
    chk("R10", doneCnt - dBase, 1);
    chkLastFull("R10");
    model(1, 0);
    chk("R10", curFields(), expFields());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule